// File: doc/BRIEF.md
# Cascaded Input Serializer Reader

This block sits on the host side of a chain of eight-channel parallel-in, serial-out input serializers that share one load line, one active-low clock-enable line and one serial clock. A one-cycle start request makes it capture a snapshot of all field inputs. It pulls the load line low, releases it, enables the chain and then produces one serial clock rising edge per chain bit. On each of those bits it samples the returning data line and shifts the bit into an assembly register. When the last bit is in, it presents the whole word and raises a one-cycle done strobe.

Every link timing figure is a parameter in picoseconds. Each one is converted to whole system clock cycles, always rounded up, and never less than one cycle. These figures are the load pulse width, the recovery from load to the first clock edge, the enable setup, the serial clock phase width, the serial clock period and the chain's output delay. An optional pair-merge mode ORs each pair of neighbouring channels into one bit. This suits inputs that are wired in parallel to double the sink current.

Top module: `serchain_reader`

## Requirements
- R1: While reset is high and afterwards until the first start, ld_n_o and ce_n_o are 1, sclk_o is 0, done_o is 0 and data_o is all zeros.
- R2: A start accepted while idle drives ld_n_o low for exactly LOAD_CYC = ceil(LOAD_MIN_PS / CLK_PERIOD_PS) cycles (at least 1), and ld_n_o falls once per read.
- R3: ce_n_o falls in the same cycle that ld_n_o rises. sclk_o stays low while ld_n_o is low. The first sclk_o rising edge comes GAP_CYC + HALF_CYC cycles after ld_n_o rises. GAP_CYC is the larger of the rounded-up recovery and enable-setup times. HALF_CYC is the largest of three figures: the rounded-up phase minimum, half the rounded-up clock period minimum, and half the rounded-up output delay.
- R4: Each read produces exactly NUM_DEV*CH_PER_DEV sclk_o rising edges. Every high and every low phase between edges lasts HALF_CYC cycles. sclk_o rises only while ce_n_o is 0. ce_n_o returns to 1 when sclk_o falls for the last time.
- R5: sdi_i is sampled in the last system cycle of each sclk_o low phase, before the rising edge that advances the chain.
- R6: Unmerged, data_o[d*CH_PER_DEV + c] holds channel c of device d. Device 0 is the chain head, whose serial input is tied off. Device NUM_DEV-1 drives sdi_i. The first bit received (channel CH_PER_DEV-1 of device NUM_DEV-1) lands in the top bit of data_o.
- R7: With merge_i high when the start is accepted, data_o[j] = raw[2j] | raw[2j+1] for j below half the width, and the upper half of data_o is zero. merge_i is looked at only when a start is accepted.
- R8: done_o is high for exactly one cycle per read. data_o takes its new value in that cycle and holds it until the next done_o.
- R9: A start request while a read is in progress is ignored: no second load pulse, a single done_o, and the result of the first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle read request |
| merge_i | input | 1 | Pair-merge select, taken when a start is accepted |
| sdi_i | input | 1 | Serial data returned by the last device of the chain |
| ld_n_o | output | 1 | Active-low parallel load to all devices |
| ce_n_o | output | 1 | Active-low serial clock enable to all devices |
| sclk_o | output | 1 | Serial clock to all devices |
| done_o | output | 1 | One-cycle strobe marking a new result |
| data_o | output | NUM_DEV*CH_PER_DEV | Assembled (or merged) channel word |

## Verification
Several properties hold on every cycle, so the embedded assertions check them. The serial clock stays low during load and rises only while the chain is enabled. The load pulse never ends early. A busy start never causes a new load. The done strobe lasts one cycle, and a result is only released after the full bit count. Other behaviour depends on what the chain sends back, so only the bench scenarios can show it. That covers the bit ordering across devices and channels, the late sampling point, pair merging, and the latching of the merge select against mid-read changes. The bench uses a behavioural chain with a short output delay for these. The same holds for the exact cycle counts of the load, gap and phases, which the bench measures at the pins.

// File: rtl/serchain_pkg.sv
package serchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_GAP,
        ST_SHIFT,
        ST_FINISH
    } rd_state_e;

    typedef struct packed {
        logic ld_n;
        logic ce_n;
        logic sclk;
    } link_ctl_t;

    // Whole system cycles covering a time span, rounded up, never zero.
    function automatic int unsigned cyc_ceil(input int unsigned span_ps,
                                             input int unsigned period_ps);
        int unsigned c;
        c = (span_ps + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Ceiling of a half, used when a span must be covered by two phases.
    function automatic int unsigned half_up(input int unsigned c);
        return (c + 1) / 2;
    endfunction

endpackage

// File: rtl/rd_sequencer.sv
module rd_sequencer
    import serchain_pkg::*;
#(
    parameter int unsigned TOTAL    = 32,
    parameter int unsigned LOAD_CYC = 1,
    parameter int unsigned GAP_CYC  = 1,
    parameter int unsigned HALF_CYC = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    output link_ctl_t ctl_o,
    output logic      accept_o,
    output logic      sample_o,
    output logic      finish_o
);

    localparam int unsigned CNT_MAX = max_u(max_u(LOAD_CYC, GAP_CYC), HALF_CYC);
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam int unsigned BW      = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int unsigned RW      = CW + 1;

    localparam logic [CW-1:0] LOAD_LD = CW'(LOAD_CYC - 1);
    localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] HALF_LD = CW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BC_LAST = BW'(TOTAL - 1);

    rd_state_e      st_q;
    logic [CW-1:0]  cnt_q;
    logic [BW-1:0]  bc_q;
    logic           ld_q;
    logic           ce_q;
    logic           sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            bc_q   <= '0;
            ld_q   <= 1'b1;
            ce_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q  <= ST_LOAD;
                        ld_q  <= 1'b0;
                        cnt_q <= LOAD_LD;
                    end
                end
                ST_LOAD: begin
                    if (cnt_q == '0) begin
                        st_q  <= ST_GAP;
                        ld_q  <= 1'b1;
                        ce_q  <= 1'b0;
                        cnt_q <= GAP_LD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == '0) begin
                        st_q  <= ST_SHIFT;
                        cnt_q <= HALF_LD;
                        bc_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        cnt_q  <= HALF_LD;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bc_q == BC_LAST) begin
                            st_q <= ST_FINISH;
                            ce_q <= 1'b1;
                        end else begin
                            bc_q  <= bc_q + 1'b1;
                            cnt_q <= HALF_LD;
                        end
                    end
                end
                ST_FINISH: st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl_o.ld_n = ld_q;
    assign ctl_o.ce_n = ce_q;
    assign ctl_o.sclk = sclk_q;
    assign accept_o   = (st_q == ST_IDLE) && start_i;
    assign sample_o   = (st_q == ST_SHIFT) && (cnt_q == '0) && !sclk_q;
    assign finish_o   = (st_q == ST_FINISH);

    // Saturating length of the current load-low run, for the width check.
    logic [RW-1:0] ld_run_q;
    always_ff @(posedge clk) begin
        if (rst || ld_q) begin
            ld_run_q <= '0;
        end else if (ld_run_q != {RW{1'b1}}) begin
            ld_run_q <= ld_run_q + 1'b1;
        end
    end

    // R2
    load_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_q) |-> (ld_run_q >= RW'(LOAD_CYC)));

    // R3
    sclk_quiet_in_load_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_q |-> !sclk_q);

    // R4
    rise_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_q) |-> (!ce_q && $past(!ce_q)));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && start_i) |=> !$fell(ld_q));

endmodule

// File: rtl/pair_merge.sv
module pair_merge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] merged_o
);

    localparam int unsigned HALF_W = WIDTH / 2;

    for (genvar j = 0; j < HALF_W; j++) begin : g_pair
        assign merged_o[j] = raw_i[2*j] | raw_i[2*j+1];
    end

    for (genvar k = HALF_W; k < WIDTH; k++) begin : g_zero
        assign merged_o[k] = 1'b0;
    end

endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
    parameter int unsigned TOTAL = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             merge_i,
    input  logic             sample_i,
    input  logic             finish_i,
    input  logic             sdi_i,
    output logic [TOTAL-1:0] data_o,
    output logic             done_o
);

    localparam int unsigned SW = $clog2(TOTAL + 1);

    logic [TOTAL-1:0] raw_q;
    logic [TOTAL-1:0] merged;
    logic [TOTAL-1:0] data_q;
    logic [SW-1:0]    smp_cnt_q;
    logic             merge_q;
    logic             done_q;

    pair_merge #(.WIDTH(TOTAL)) i_pair_merge (
        .raw_i    (raw_q),
        .merged_o (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            smp_cnt_q <= '0;
            merge_q   <= 1'b0;
        end else if (accept_i) begin
            raw_q     <= '0;
            smp_cnt_q <= '0;
            merge_q   <= merge_i;
        end else if (sample_i) begin
            raw_q     <= {raw_q[TOTAL-2:0], sdi_i};
            smp_cnt_q <= smp_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (finish_i) begin
                data_q <= merge_q ? merged : raw_q;
            end
        end
    end

    assign data_o = data_q;
    assign done_o = done_q;

    // R4
    full_count_chk: assert property (@(posedge clk) disable iff (rst)
        finish_i |-> (smp_cnt_q == SW'(TOTAL)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(data_q));

endmodule

// File: rtl/serchain_reader.sv
module serchain_reader
    import serchain_pkg::*;
#(
    parameter int unsigned NUM_DEV            = 4,
    parameter int unsigned CH_PER_DEV         = 8,
    parameter int unsigned CLK_PERIOD_PS      = 10000,
    parameter int unsigned LOAD_MIN_PS        = 6000,
    parameter int unsigned RECOV_MIN_PS       = 2000,
    parameter int unsigned CESU_MIN_PS        = 4000,
    parameter int unsigned PHASE_MIN_PS       = 4000,
    parameter int unsigned SCLK_MIN_PERIOD_PS = 10000,
    parameter int unsigned SOUT_DELAY_PS      = 10000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          merge_i,
    input  logic                          sdi_i,
    output logic                          ld_n_o,
    output logic                          ce_n_o,
    output logic                          sclk_o,
    output logic                          done_o,
    output logic [NUM_DEV*CH_PER_DEV-1:0] data_o
);

    localparam int unsigned TOTAL    = NUM_DEV * CH_PER_DEV;
    localparam int unsigned LOAD_CYC = cyc_ceil(LOAD_MIN_PS, CLK_PERIOD_PS);
    localparam int unsigned GAP_CYC  = max_u(cyc_ceil(RECOV_MIN_PS, CLK_PERIOD_PS),
                                             cyc_ceil(CESU_MIN_PS, CLK_PERIOD_PS));
    // A phase must meet its own minimum; two phases must cover the clock
    // period and the chain's output delay, since sampling ends the low phase.
    localparam int unsigned HALF_CYC = max_u(cyc_ceil(PHASE_MIN_PS, CLK_PERIOD_PS),
                                       max_u(half_up(cyc_ceil(SCLK_MIN_PERIOD_PS, CLK_PERIOD_PS)),
                                             half_up(cyc_ceil(SOUT_DELAY_PS, CLK_PERIOD_PS))));

    link_ctl_t ctl;
    logic      accept;
    logic      sample;
    logic      finish;

    rd_sequencer #(
        .TOTAL    (TOTAL),
        .LOAD_CYC (LOAD_CYC),
        .GAP_CYC  (GAP_CYC),
        .HALF_CYC (HALF_CYC)
    ) i_rd_sequencer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .ctl_o    (ctl),
        .accept_o (accept),
        .sample_o (sample),
        .finish_o (finish)
    );

    rd_capture #(
        .TOTAL (TOTAL)
    ) i_rd_capture (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .merge_i  (merge_i),
        .sample_i (sample),
        .finish_i (finish),
        .sdi_i    (sdi_i),
        .data_o   (data_o),
        .done_o   (done_o)
    );

    assign ld_n_o = ctl.ld_n;
    assign ce_n_o = ctl.ce_n;
    assign sclk_o = ctl.sclk;

    // R1
    idle_lines_chk: assert property (@(posedge clk)
        rst |=> (ld_n_o && ce_n_o && !sclk_o && !done_o));

endmodule

// File: tb/test_serchain_reader.sv
module test_serchain_reader;

    localparam int NDEV  = 4;
    localparam int NCH   = 8;
    localparam int W     = NDEV * NCH;
    localparam int PER   = 10000;
    localparam int LD_PS = 25000;
    localparam int RC_PS = 12000;
    localparam int CE_PS = 4000;
    localparam int PH_PS = 15000;
    // Expected cycle counts worked out from the chosen times (ceil rule).
    localparam int E_LOAD = (LD_PS + PER - 1) / PER;                        // 3
    localparam int E_GAP  = ((RC_PS + PER - 1) / PER > (CE_PS + PER - 1) / PER)
                            ? (RC_PS + PER - 1) / PER : (CE_PS + PER - 1) / PER; // 2
    localparam int E_HALF = (PH_PS + PER - 1) / PER;                        // 2

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         merge = 1'b0;
    logic         sdi;
    logic         ld_n, ce_n, sclk, done;
    logic [W-1:0] data;

    always #5ns clk = ~clk;

    serchain_reader #(
        .NUM_DEV      (NDEV),
        .CH_PER_DEV   (NCH),
        .CLK_PERIOD_PS(PER),
        .LOAD_MIN_PS  (LD_PS),
        .RECOV_MIN_PS (RC_PS),
        .CESU_MIN_PS  (CE_PS),
        .PHASE_MIN_PS (PH_PS)
    ) i_serchain_reader (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .merge_i (merge),
        .sdi_i   (sdi),
        .ld_n_o  (ld_n),
        .ce_n_o  (ce_n),
        .sclk_o  (sclk),
        .done_o  (done),
        .data_o  (data)
    );

    // Behavioural chain: one long register, head SIP tied low, 3 ns delay.
    logic [W-1:0] field = '0;
    logic [W-1:0] chain = '0;
    always @(posedge sclk or negedge ld_n) begin
        #3ns;
        if (!ld_n)      chain <= field;
        else if (!ce_n) chain <= {chain[W-2:0], 1'b0};
    end
    assign sdi = chain[W-1];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] f, input bit m);
        logic [W-1:0] r;
        if (!m) return f;
        r = '0;
        for (int j = 0; j < W / 2; j++) r[j] = f[2*j] | f[2*j+1];
        return r;
    endfunction

    // Pin monitor, sampled on the falling system clock edge.
    int  ld_falls, ld_run, ld_width, after_ld, first_gap, ce_after, ce_gap;
    int  rises, bad_rise, hi_run, lo_run, min_hi, max_hi, min_lo, max_lo, done_cnt;
    logic p_ld = 1'b1, p_ce = 1'b1, p_sclk = 1'b0;

    task automatic clear_mon();
        ld_falls = 0; ld_run = 0; ld_width = 0; after_ld = 0; first_gap = -1;
        ce_after = 0; ce_gap = -1; rises = 0; bad_rise = 0; hi_run = 0; lo_run = 0;
        min_hi = 1000; max_hi = 0; min_lo = 1000; max_lo = 0; done_cnt = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (p_ld && !ld_n) ld_falls++;
            if (!ld_n) ld_run++;
            if (!p_ld && ld_n) begin ld_width = ld_run; ld_run = 0; after_ld = 0; end
            else after_ld++;
            if (p_ce && !ce_n) ce_after = 0; else ce_after++;
            if (!p_sclk && sclk) begin
                rises++;
                if (ce_n) bad_rise++;
                if (rises == 1) begin first_gap = after_ld; ce_gap = ce_after; end
                else begin
                    if (lo_run < min_lo) min_lo = lo_run;
                    if (lo_run > max_lo) max_lo = lo_run;
                end
                lo_run = 0;
            end
            if (p_sclk && !sclk) begin
                if (hi_run < min_hi) min_hi = hi_run;
                if (hi_run > max_hi) max_hi = hi_run;
                hi_run = 0;
            end
            if (sclk) hi_run++; else lo_run++;
            if (done) done_cnt++;
        end
        p_ld = ld_n; p_ce = ce_n; p_sclk = sclk;
    end

    task automatic do_read(input logic [W-1:0] f, input bit m, input bit intrude);
        int n;
        logic [W-1:0] got;
        field = f;
        clear_mon();
        @(negedge clk); start = 1'b1; merge = m;
        @(negedge clk); start = 1'b0;
        if (intrude) begin
            repeat (20) @(negedge clk);
            start = 1'b1; merge = !m; field = ~f;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        got = data;
        check(done, "R8 done seen", W'(done), W'(1));
        if (m) check(got === exp_word(f, m), "R7 merged word", got, exp_word(f, m));
        else   check(got === exp_word(f, m), "R6 ordering", got, exp_word(f, m));
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R8 done width", W'(done_cnt), W'(1));
        check(data === got, "R8 data held", data, got);
        check(ld_falls == 1, "R9/R2 load count", W'(ld_falls), W'(1));
        check(ld_width == E_LOAD, "R2 load width", W'(ld_width), W'(E_LOAD));
        check(first_gap == E_GAP + E_HALF, "R3 load to first edge", W'(first_gap), W'(E_GAP + E_HALF));
        check(ce_gap == E_GAP + E_HALF, "R3 enable to first edge", W'(ce_gap), W'(E_GAP + E_HALF));
        check(rises == W, "R4 edge count", W'(rises), W'(W));
        check(bad_rise == 0, "R4 edge while disabled", W'(bad_rise), W'(0));
        check(min_hi == E_HALF && max_hi == E_HALF, "R4 high phase", W'(max_hi), W'(E_HALF));
        check(min_lo == E_HALF && max_lo == E_HALF, "R4 low phase", W'(max_lo), W'(E_HALF));
        check(ld_n && ce_n && !sclk, "R4 lines idle after read",
              W'({ld_n, ce_n, sclk}), W'(3'b110));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        clear_mon();
        repeat (4) @(negedge clk);
        // R1 reset values while reset is held
        check(ld_n === 1'b1, "R1 ld_n", W'(ld_n), W'(1));
        check(ce_n === 1'b1, "R1 ce_n", W'(ce_n), W'(1));
        check(sclk === 1'b0, "R1 sclk", W'(sclk), W'(0));
        check(done === 1'b0, "R1 done", W'(done), W'(0));
        check(data === '0,   "R1 data", data, '0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(ld_n && ce_n && !sclk && !done, "R1 idle after reset",
              W'({ld_n, ce_n, sclk, done}), W'(4'b1100));

        // Directed corners: R5 and R6 via first and last bit positions
        do_read(32'h8000_0000, 1'b0, 1'b0);
        do_read(32'h0000_0001, 1'b0, 1'b0);
        do_read(32'h0000_0000, 1'b0, 1'b0);
        do_read(32'hFFFF_FFFF, 1'b0, 1'b0);
        do_read(32'h0123_4567, 1'b0, 1'b0);
        // R7 merge corners
        do_read(32'hAAAA_AAAA, 1'b1, 1'b0);
        do_read(32'h5555_0000, 1'b1, 1'b0);
        do_read(32'h8000_0001, 1'b1, 1'b0);
        // R9 busy start and R7 mid-read merge change
        do_read(32'hC3A5_0F96, 1'b0, 1'b1);
        do_read(32'h1248_8421, 1'b1, 1'b1);

        seed = $urandom(32'd2718);
        for (int i = 0; i < 16; i++) begin
            do_read(W'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule